// File: doc/BRIEF.md
# Programmable Output Gain and Rounding Stage

This stage takes the signed 32-bit result of a filter accumulator and scales it by a programmable gain. The gain is a 4-bit mantissa fraction applied as (1 + F/16), multiplied by a power of two set by a 4-bit exponent S. The scaled value is then rounded to a selectable number of most significant bits of a 24-bit signed output word. If the result does not fit, the output clamps to positive or negative full scale and an overflow flag is raised. A single 16-bit control word sets the gain and the rounding width, and software writes it through a plain write port.

Samples enter on a valid/ready stream and leave on a registered valid/ready stream. Back-pressure works as follows. The whole two-stage pipeline advances only when the output register is empty or the consumer asserts `out_ready`. `in_ready` equals that advance condition. A held output therefore stops both stages, and a sample is accepted only when `in_valid` and `in_ready` are both high at a rising edge. While `out_valid` is high, `out_data` and `out_ovf` do not change until `out_ready` is seen high.

Top module: `gain_round_stage`

## Requirements
- R1: The control word carries F in bits 3:0, S in bits 7:4 and the round code in bits 14:8. Bit 15 has no effect on any output.
- R2: Before rounding, the scaled value is floor(acc × (16+F) × 2^(S−12)). This equals acc × 2^(S−20) × (1+F/16) × 2^12. With S=5 and F=0 the value is acc/8, so accumulator bit 26 (the MSB of a 12-bit input after a coefficient sum of 2^15) lands on output bit 23.
- R3: The round code selects how many MSBs of the 24-bit output are kept, all other bits being cleared: 0x01 keeps 8 MSBs and clears 16 bits; 0x02 keeps 10 and clears 14; 0x04 keeps 12 and clears 12; 0x08 keeps 14 and clears 10; 0x10 keeps 16 and clears 8; 0x20 keeps 20 and clears 4. Rounding adds half of the lowest kept bit and then clears the bits below it (round half up, also for negative values).
- R4: Code 0x00, code 0x40 (24 MSBs) and every code not listed in R3 leave the floored value unrounded.
- R5: Saturation is applied after rounding. A value above 0x7FFFFF gives 0x7FFFFF, and a value below −0x800000 gives 0x800000. In both cases `out_ovf` is 1 for that sample. Otherwise `out_ovf` is 0, and exact full-scale values do not flag.
- R6: Reset clears the control word to zero (S=0, F=0, truncate), drops `out_valid` and leaves `in_ready` high.
- R7: When `out_ready` is high, a sample accepted at rising edge k appears on the output, with `out_valid` high, after rising edge k+1.
- R8: A control write at the same edge that accepts a sample does not affect that sample. It does affect the next accepted sample.
- R9: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the output holds its data and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word: fraction, exponent, round code |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Stage can accept a sample this cycle |
| in_data | input | 32 | Signed accumulator sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts the output this cycle |
| out_data | output | 24 | Signed scaled, rounded and saturated sample |
| out_ovf | output | 1 | Saturation occurred on this output sample |

## Verification
A control word takes effect for a sample presented at the edge after the write. A result and its overflow flag are due just after the second rising edge that counts the accepting one, so the bench drives inputs on falling edges and reads the output one time unit after that edge. A control write that coincides with an accepted sample is checked on two consecutive outputs, the first using the old setting and the second the new one. The stall test holds `out_ready` low for several cycles and confirms that the output is unchanged and `in_ready` is low before release.

// File: rtl/gain_round_pkg.sv
package gain_round_pkg;
  localparam int FRAC_W = 4;
  localparam int EXP_W  = 4;
  localparam int CODE_W = 7;
  localparam int CTRL_W = 16;

  // Field order fixes bit positions: [15] spare, [14:8] code, [7:4] exponent, [3:0] fraction
  typedef struct packed {
    logic              spare;
    logic [CODE_W-1:0] code;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } gain_ctrl_t;

  // Number of low output bits cleared by rounding; 0 means no rounding
  function automatic int unsigned drop_count(input logic [CODE_W-1:0] code, input int unsigned out_w);
    int unsigned keep;
    case (code)
      7'h01:   keep = 8;
      7'h02:   keep = 10;
      7'h04:   keep = 12;
      7'h08:   keep = 14;
      7'h10:   keep = 16;
      7'h20:   keep = 20;
      7'h40:   keep = 24;
      default: keep = out_w;
    endcase
    return (keep >= out_w) ? 0 : out_w - keep;
  endfunction
endpackage

// File: rtl/gain_ctrl_reg.sv
module gain_ctrl_reg
  import gain_round_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output gain_ctrl_t        ctrl
);
  logic unused_spare;
  assign unused_spare = wdata[CTRL_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (we) begin
      ctrl.code  <= wdata[14:8];
      ctrl.expo  <= wdata[7:4];
      ctrl.frac  <= wdata[3:0];
      ctrl.spare <= 1'b0;
    end
  end
endmodule

// File: rtl/gain_mult.sv
module gain_mult
  import gain_round_pkg::*;
#(
  parameter int IN_W   = 32,
  parameter int OUT_W  = 24,
  localparam int PROD_W = IN_W + FRAC_W + 2,
  localparam int DROP_W = $clog2(OUT_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     in_valid,
  input  logic [IN_W-1:0]          in_data,
  input  gain_ctrl_t               ctrl,
  output logic                     s1_valid,
  output logic signed [PROD_W-1:0] s1_prod,
  output logic [EXP_W-1:0]         s1_expo,
  output logic [DROP_W-1:0]        s1_drop
);
  logic signed [FRAC_W+1:0]  mant;
  logic signed [PROD_W-1:0]  prod;

  assign mant = $signed({2'b01, ctrl.frac});
  assign prod = PROD_W'($signed(in_data)) * PROD_W'(mant);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_prod  <= '0;
      s1_expo  <= '0;
      s1_drop  <= '0;
    end else if (en) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_prod <= prod;
        s1_expo <= ctrl.expo;
        s1_drop <= DROP_W'(drop_count(ctrl.code, OUT_W));
      end
    end
  end
endmodule

// File: rtl/round_sat.sv
module round_sat
  import gain_round_pkg::*;
#(
  parameter int IN_W     = 32,
  parameter int OUT_W    = 24,
  parameter int EXP_BIAS = 12,
  localparam int PROD_W  = IN_W + FRAC_W + 2,
  localparam int EXP_MAX = (1 << EXP_W) - 1,
  localparam int PRE_L   = EXP_MAX - EXP_BIAS,
  localparam int WIDE_W  = PROD_W + PRE_L + 2,
  localparam int DROP_W  = $clog2(OUT_W + 1)
) (
  input  logic signed [PROD_W-1:0] prod,
  input  logic [EXP_W-1:0]         expo,
  input  logic [DROP_W-1:0]        drop,
  output logic [OUT_W-1:0]         res,
  output logic                     ovf
);
  localparam logic signed [WIDE_W-1:0] MAXV = WIDE_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [WIDE_W-1:0] MINV = ~MAXV;
  localparam logic signed [WIDE_W-1:0] ONE  = WIDE_W'(1);

  logic signed [WIDE_W-1:0] wide, shifted, half, rounded;
  logic [EXP_W-1:0]         rshift;

  always_comb begin
    rshift  = EXP_W'(EXP_MAX) - expo;
    wide    = WIDE_W'(prod) <<< PRE_L;
    shifted = wide >>> rshift;
    half    = (drop == '0) ? '0 : (ONE << (drop - DROP_W'(1)));
    rounded = (shifted + half) & ~((ONE << drop) - ONE);
    ovf     = 1'b0;
    if (rounded > MAXV) begin
      res = MAXV[OUT_W-1:0];
      ovf = 1'b1;
    end else if (rounded < MINV) begin
      res = MINV[OUT_W-1:0];
      ovf = 1'b1;
    end else begin
      res = rounded[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/gain_round_stage.sv
module gain_round_stage
  import gain_round_pkg::*;
#(
  parameter int IN_W     = 32,
  parameter int OUT_W    = 24,
  parameter int EXP_BIAS = 12,
  localparam int PROD_W  = IN_W + FRAC_W + 2,
  localparam int DROP_W  = $clog2(OUT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_ovf
);
  localparam logic [OUT_W-1:0] POS_FS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_FS = {1'b1, {(OUT_W-1){1'b0}}};

  gain_ctrl_t               ctrl;
  logic                     adv;
  logic                     s1_valid;
  logic signed [PROD_W-1:0] s1_prod;
  logic [EXP_W-1:0]         s1_expo;
  logic [DROP_W-1:0]        s1_drop;
  logic [OUT_W-1:0]         rs_data;
  logic                     rs_ovf;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  gain_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata), .ctrl(ctrl)
  );

  gain_mult #(.IN_W(IN_W), .OUT_W(OUT_W)) u_mult (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_valid(in_valid), .in_data(in_data),
    .ctrl(ctrl), .s1_valid(s1_valid), .s1_prod(s1_prod), .s1_expo(s1_expo),
    .s1_drop(s1_drop)
  );

  round_sat #(.IN_W(IN_W), .OUT_W(OUT_W), .EXP_BIAS(EXP_BIAS)) u_rnd (
    .prod(s1_prod), .expo(s1_expo), .drop(s1_drop), .res(rs_data), .ovf(rs_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_data <= rs_data;
        out_ovf  <= rs_ovf;
      end
    end
  end

  // R5: a flagged sample carries a full-scale value
  a_r5_ovf_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> (out_data == POS_FS) || (out_data == NEG_FS));

  // R9: a stalled output keeps its value
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ovf));

  // R9: an empty output register never refuses input
  a_r9_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R7: an accepted sample occupies the first stage one edge later
  a_r7_stage_fill: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_valid);

  // R3: an unsaturated rounded result has its cleared bits at zero
  a_r3_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !rs_ovf |-> (rs_data & OUT_W'((64'd1 << s1_drop) - 64'd1)) == '0);
endmodule

// File: tb/gain_round_stage_tb.sv
module gain_round_stage_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_data;
  logic        out_ovf;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_round_stage u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ovf(out_ovf)
  );

  // {req number, control word, accumulator, expected data, expected overflow}
  localparam logic [76:0] VEC [NVEC] = '{
    {4'd2, 16'h0050, 32'h03FF8000, 24'h7FF000, 1'b0},  // R2 unity gain
    {4'd5, 16'h0050, 32'hFC000000, 24'h800000, 1'b0},  // R5 exact negative full scale
    {4'd2, 16'h0058, 32'h00800000, 24'h180000, 1'b0},  // R2 fraction 8 gives 1.5x
    {4'd5, 16'h0060, 32'h03FF8000, 24'h7FFFFF, 1'b1},  // R5 positive clamp
    {4'd5, 16'h0060, 32'hFC000000, 24'h800000, 1'b1},  // R5 negative clamp
    {4'd3, 16'h0150, 32'h0091A2B0, 24'h120000, 1'b0},  // R3 8 MSBs, round down
    {4'd3, 16'h0150, 32'h00940000, 24'h130000, 1'b0},  // R3 8 MSBs, half rounds up
    {4'd3, 16'h1050, 32'h0091A7F8, 24'h123500, 1'b0},  // R3 16 MSBs
    {4'd3, 16'h2050, 32'h000000B8, 24'h000010, 1'b0},  // R3 20 MSBs
    {4'd4, 16'h4050, 32'h0091A2B8, 24'h123457, 1'b0},  // R4 24 MSBs is no rounding
    {4'd4, 16'h0350, 32'h0091A7F8, 24'h1234FF, 1'b0},  // R4 invalid code truncates
    {4'd3, 16'h0850, 32'hFFFFE800, 24'hFFFC00, 1'b0},  // R3 negative value, 14 MSBs
    {4'd5, 16'h0150, 32'h03FF8000, 24'h7FFFFF, 1'b1},  // R5 rounding pushes past max
    {4'd2, 16'h0000, 32'hFFFFFFFF, 24'hFFFFFF, 1'b0},  // R2 smallest gain floors
    {4'd2, 16'h00FF, 32'h000003E8, 24'h03C8C0, 1'b0},  // R2 largest gain
    {4'd1, 16'h8050, 32'h03FF8000, 24'h7FF000, 1'b0}   // R1 spare bit ignored
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [15:0] w);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = w;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  // Present one sample at a falling edge, wait for its result two edges later
  task automatic run_one(input logic [31:0] acc);
    in_valid = 1'b1; in_data = acc;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL R7 watchdog act=%h exp=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R6: reset state at the ports
    check(out_valid == 1'b0, "R6 out_valid", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R6 in_ready", 32'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    // R6: cleared control word means S=0, F=0, truncate: acc/256
    @(negedge clk);
    run_one(32'h12345600);
    check(out_valid == 1'b1 && out_data == 24'h123456, "R6 reset gain", 32'(out_data), 32'h123456);

    for (int i = 0; i < NVEC; i++) begin
      logic [76:0] v;
      string tag;
      v = VEC[i];
      write_ctrl(v[72:57]);
      run_one(v[56:25]);
      tag = $sformatf("R%0d vec%0d", v[76:73], i);
      check(out_valid && out_data == v[24:1] && out_ovf == v[0], tag,
            {7'd0, out_ovf, out_data}, {7'd0, v[0], v[24:1]});
    end

    // R7: output due exactly one edge after the accepting edge, gone the edge after
    write_ctrl(16'h0050);
    in_valid = 1'b1; in_data = 32'h00000320;
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R7 not early", 32'(out_valid), 0);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    check(out_valid && out_data == 24'd100, "R7 on time", 32'(out_data), 100);
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R7 single beat", 32'(out_valid), 0);

    // R8: write at the same edge as a sample applies from the next sample
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = 16'h0150;
    in_valid = 1'b1; in_data = 32'h00940000;
    @(negedge clk);
    ctrl_we = 1'b0;
    @(posedge clk); #1;
    check(out_data == 24'h128000, "R8 old setting", 32'(out_data), 32'h128000);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    check(out_data == 24'h130000, "R8 new setting", 32'(out_data), 32'h130000);

    // R9: back-pressure
    write_ctrl(16'h0050);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 32'd800;
    @(negedge clk); in_data = 32'd1600;
    @(negedge clk); in_valid = 1'b0;
    check(out_valid && out_data == 24'd100 && !in_ready, "R9 stall begins",
          {in_ready, 7'd0, out_data}, 32'd100);
    repeat (3) @(negedge clk);
    check(out_valid && out_data == 24'd100, "R9 stall holds", 32'(out_data), 100);
    check(in_ready == 1'b0, "R9 in_ready low", 32'(in_ready), 0);
    out_ready = 1'b1;
    @(posedge clk); #1;
    check(out_valid && out_data == 24'd200, "R9 release", 32'(out_data), 200);
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R9 drained", 32'(out_valid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule